// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host read and write a byte-wide asynchronous static RAM with a 19-bit address space. The host raises a request strobe with a read/write flag, an address and (for writes) a data byte. The controller then runs the memory's active-low chip select, output enable and write enable through a fixed sequence. It pulses a done flag for one clock when the access is over, and read data is valid at that point.

The length of every strobe phase is a count of clock cycles. Each count is worked out at elaboration by taking a nanosecond limit, dividing it by the clock period and rounding up, with a floor of one cycle. With the default 10 ns clock this gives:

- a read strobe of 9 cycles;
- a write-enable pulse of 8 cycles, followed by 1 recovery cycle;
- a bus-release wait of 4 cycles after every read.

Between accesses the memory is deselected, with all three strobes high and the controller's data drivers off.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and in idle, mem_cs_n_o, mem_oe_n_o and mem_we_n_o are 1, mem_dq_oe_o is 0 and done_o is 0.
- R2: For a read (wr_i = 0), mem_cs_n_o and mem_oe_n_o fall on the accepting edge and stay low for exactly max(ceil(85/P), ceil(50/P)) cycles (P = clock period in ns), while mem_we_n_o stays 1.
- R3: The memory's data is sampled at the clock edge that ends the read strobe. It appears on rdata_o in the same cycle as done_o, which goes high exactly RD cycles after the accepting edge, for one clock only.
- R4: After a read strobe ends, the controller waits at least ceil(35/P) full cycles with all strobes high before it accepts another request. It never enables its data drivers until more than that many cycles have passed since mem_oe_n_o rose.
- R5: For a write (wr_i = 1), mem_cs_n_o falls on the accepting edge. mem_we_n_o is low for exactly WP = max(ceil(65/P), ceil(75/P), ceil(50/P)) cycles, then high for max(1, ceil(85/P) - WP) cycles with chip select still low. mem_oe_n_o stays 1 throughout.
- R6: During a write, mem_dq_oe_o is 1 with the latched data on mem_dq_o from the accepting edge until chip select rises, and it drops on the same edge as chip select.
- R7: done_o for a write goes high exactly WP + recovery cycles after the accepting edge, for one clock.
- R8: Address and write data are latched on acceptance and held on mem_addr_o and mem_dq_o until the access ends, even if addr_i, wdata_i or wr_i change.
- R9: A request that is present while an access is in progress is ignored. No extra done pulse occurs and no memory location is touched.
- R10: mem_oe_n_o and mem_we_n_o are never low together, and mem_dq_oe_o is never 1 while mem_oe_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, sampled in idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Access address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with done_o |
| done_o | output | 1 | One-clock pulse at access completion |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_addr_o | output | 19 | Memory address bus |
| mem_dq_o | output | 8 | Data bus value driven by the controller |
| mem_dq_i | input | 8 | Data bus value seen from the memory |
| mem_dq_oe_o | output | 1 | Controller data driver enable |

## Verification
The bench sets each request half a cycle before an edge and takes the first half-cycle sample that shows chip select low as cycle zero. From there it expects:

- done_o on sample 9 for a read and on sample 9 (8 + 1) for a write;
- done_o low again on the following sample.

A memory model in the bench returns inverted data until chip select and output enable have both been low for 85 ns of half-cycle samples, so a read that samples early shows up as a data mismatch.

Strobe widths are measured as runs of half-cycle samples. The same monitor checks the driver-enable rise against the cycle count since output enable rose. All expected counts come from bench functions that apply the same rounding to the nanosecond limits.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RD_TURN,
        ST_WRITE,
        ST_WR_REC
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       cs_n;
        logic       oe_n;
        logic       we_n;
        logic       dq_oe;
        logic       done;
    } seq_regs_t;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // A freshly loaded non-zero phase must not report expiry on the next cycle.
    p_load_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !expired_o);

endmodule

// File: rtl/sram_bus_latch.sv
module sram_bus_latch #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sample_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } latch_regs_t;

    latch_regs_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (capture_i) begin
            lat_d.addr  = addr_i;
            lat_d.wdata = wdata_i;
        end
        if (sample_i) begin
            lat_d.rdata = dq_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign addr_o  = lat_q.addr;
    assign wdata_o = lat_q.wdata;
    assign rdata_o = lat_q.rdata;

    // The sequencer never starts a new access and ends a read on one edge.
    p_capture_sample_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture_i && sample_i));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned RD_CYC  = 9,
    parameter int unsigned HZ_CYC  = 4,
    parameter int unsigned WP_CYC  = 8,
    parameter int unsigned REC_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             wr_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             capture_o,
    output logic             sample_o,
    output logic             cs_n_o,
    output logic             oe_n_o,
    output logic             we_n_o,
    output logic             dq_oe_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD  = CNT_W'(HZ_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        load_o     = 1'b0;
        load_val_o = '0;
        capture_o  = 1'b0;
        sample_o   = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    capture_o  = 1'b1;
                    load_o     = 1'b1;
                    nxt_d.cs_n = 1'b0;
                    if (wr_i) begin
                        nxt_d.st    = ST_WRITE;
                        nxt_d.we_n  = 1'b0;
                        nxt_d.dq_oe = 1'b1;
                        load_val_o  = WP_LD;
                    end else begin
                        nxt_d.st   = ST_READ;
                        nxt_d.oe_n = 1'b0;
                        load_val_o = RD_LD;
                    end
                end
            end
            ST_READ: begin
                if (expired_i) begin
                    sample_o   = 1'b1;
                    nxt_d.done = 1'b1;
                    nxt_d.cs_n = 1'b1;
                    nxt_d.oe_n = 1'b1;
                    nxt_d.st   = ST_RD_TURN;
                    load_o     = 1'b1;
                    load_val_o = HZ_LD;
                end
            end
            ST_RD_TURN: begin
                if (expired_i) nxt_d.st = ST_IDLE;
            end
            ST_WRITE: begin
                if (expired_i) begin
                    nxt_d.we_n = 1'b1;
                    nxt_d.st   = ST_WR_REC;
                    load_o     = 1'b1;
                    load_val_o = REC_LD;
                end
            end
            ST_WR_REC: begin
                if (expired_i) begin
                    nxt_d.cs_n  = 1'b1;
                    nxt_d.dq_oe = 1'b0;
                    nxt_d.done  = 1'b1;
                    nxt_d.st    = ST_IDLE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                       dq_oe: 1'b0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cs_n_o  = cur_q.cs_n;
    assign oe_n_o  = cur_q.oe_n;
    assign we_n_o  = cur_q.we_n;
    assign dq_oe_o = cur_q.dq_oe;
    assign done_o  = cur_q.done;

    // Cycles since output enable was last low, saturating one past the wait.
    logic [CNT_W-1:0] since_oe_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_oe_q <= CNT_W'(HZ_CYC + 1);
        else if (!cur_q.oe_n)                since_oe_q <= '0;
        else if (since_oe_q <= CNT_W'(HZ_CYC)) since_oe_q <= since_oe_q + 1'b1;
    end

    p_oe_we_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n_o && !we_n_o));
    p_no_drive_under_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe_o && !oe_n_o));
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_we_rise_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> !cs_n_o);
    p_strobe_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_o || !we_n_o) |-> !cs_n_o);
    p_drive_after_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe_o) |-> (since_oe_q > CNT_W'(HZ_CYC)));
    p_drive_ends_with_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe_o) |-> $rose(cs_n_o));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned T_RCYC_NS     = 85,
    parameter int unsigned T_ACC_NS      = 85,
    parameter int unsigned T_OEACC_NS    = 50,
    parameter int unsigned T_WCYC_NS     = 85,
    parameter int unsigned T_WPW_NS      = 65,
    parameter int unsigned T_ADDR_END_NS = 75,
    parameter int unsigned T_DSET_NS     = 50,
    parameter int unsigned T_RELEASE_NS  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              mem_cs_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe_o
);
    localparam int unsigned RD_CYC = max_u(max_u(ns_to_cycles(T_RCYC_NS, CLK_PERIOD_NS),
                                                 ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS)),
                                           ns_to_cycles(T_OEACC_NS, CLK_PERIOD_NS));
    localparam int unsigned WP_CYC = max_u(max_u(ns_to_cycles(T_WPW_NS, CLK_PERIOD_NS),
                                                 ns_to_cycles(T_ADDR_END_NS, CLK_PERIOD_NS)),
                                           ns_to_cycles(T_DSET_NS, CLK_PERIOD_NS));
    localparam int unsigned WC_CYC  = ns_to_cycles(T_WCYC_NS, CLK_PERIOD_NS);
    localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned HZ_CYC  = ns_to_cycles(T_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WP_CYC), max_u(REC_CYC, HZ_CYC + 1));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             capture;
    logic             sample;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .expired_o  (expired)
    );

    sram_seq #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .HZ_CYC  (HZ_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .wr_i       (wr_i),
        .expired_i  (expired),
        .load_o     (load),
        .load_val_o (load_val),
        .capture_o  (capture),
        .sample_o   (sample),
        .cs_n_o     (mem_cs_n_o),
        .oe_n_o     (mem_oe_n_o),
        .we_n_o     (mem_we_n_o),
        .dq_oe_o    (mem_dq_oe_o),
        .done_o     (done_o)
    );

    sram_bus_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .sample_i  (sample),
        .dq_i      (mem_dq_i),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_dq_o),
        .rdata_o   (rdata_o)
    );

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));
    p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n_o |-> (mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
    localparam int CLK_NS = 10;
    localparam int ACC_NS = 85;

    function automatic int cyc(int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction
    function automatic int rd_exp();
        return mx(cyc(85), cyc(50));
    endfunction
    function automatic int wp_exp();
        return mx(mx(cyc(65), cyc(75)), cyc(50));
    endfunction
    function automatic int rec_exp();
        return (cyc(85) > wp_exp()) ? cyc(85) - wp_exp() : 1;
    endfunction
    function automatic int hz_exp();
        return cyc(35);
    endfunction
    function automatic logic [7:0] init_val(logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        done;
    logic        cs_n, oe_n, we_n, dq_oe;
    logic [18:0] maddr;
    logic [7:0]  dq_o;
    logic [7:0]  dq_i = 8'h00;

    sram_ctrl #(.CLK_PERIOD_NS(CLK_NS)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .mem_cs_n_o(cs_n),
        .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_addr_o(maddr),
        .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(bit ok, string req_tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Memory model and the reference contents the bench expects.
    logic [7:0] store [logic [18:0]];
    logic [7:0] ref_mem [logic [18:0]];
    function automatic logic [7:0] mem_get(logic [18:0] a);
        return store.exists(a) ? store[a] : init_val(a);
    endfunction
    function automatic logic [7:0] ref_get(logic [18:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    int  rd_age = 0;
    int  we_run = 0, cs_run = 0, since_oe = 1000;
    bit  we_prev = 1, cs_prev = 1, dq_prev = 0, in_write = 0, oe_in_write = 0;
    bit  clash = 0;
    int  done_seen = 0, ops_done = 0;
    logic [7:0] exp_d;

    always @(negedge clk) begin
        if (rst_n) begin
            // memory read drive with access-time model
            if (!cs_n && !oe_n && we_n) begin
                rd_age = rd_age + 1;
                dq_i   = (rd_age * CLK_NS >= ACC_NS) ? mem_get(maddr) : ~mem_get(maddr);
                if (dq_oe) clash = 1;
            end else begin
                rd_age = 0;
                dq_i   = 8'h00;
            end
            if (done) done_seen++;
            // write strobe monitor
            if (!we_n) begin
                we_run++;
                in_write = 1;
                if (!oe_n) oe_in_write = 1;
            end
            if (we_n && !we_prev) begin
                check(we_run == wp_exp(), "R5 we width", we_run, wp_exp());
                check(oe_in_write == 0, "R5 oe high in write", oe_in_write, 0);
                check(dq_oe && dq_o == exp_d, "R6 data at we rise", dq_o, exp_d);
                if (!cs_n) store[maddr] = dq_oe ? dq_o : 8'hFF;
                we_run = 0;
                oe_in_write = 0;
            end
            // chip select monitor
            if (!cs_n) cs_run++;
            if (cs_n && !cs_prev) begin
                if (in_write) begin
                    check(cs_run == wp_exp() + rec_exp(), "R5 cs width", cs_run,
                          wp_exp() + rec_exp());
                    check(dq_oe == 0, "R6 drive off with cs", dq_oe, 0);
                end else begin
                    check(cs_run == rd_exp(), "R2 read strobe width", cs_run, rd_exp());
                end
                cs_run = 0;
                in_write = 0;
            end
            // turnaround monitor
            since_oe = !oe_n ? 0 : since_oe + 1;
            if (dq_oe && !dq_prev)
                check(since_oe >= hz_exp() + 1, "R4 turnaround", since_oe, hz_exp() + 1);
            we_prev = we_n;
            cs_prev = cs_n;
            dq_prev = dq_oe;
        end
    end

    // One access; cycle zero is the first sample showing chip select low.
    task automatic do_op(bit w, logic [18:0] a, logic [7:0] d, bit disturb);
        int n;
        int wait_n;
        @(negedge clk);
        req = 1; wr = w; addr = a; wdata = d; exp_d = d;
        @(negedge clk);
        wait_n = 0;
        while (cs_n && wait_n < 50) begin
            @(negedge clk);
            wait_n++;
        end
        if (disturb) begin
            addr = ~a; wdata = ~d; wr = ~w;
        end else begin
            req = 0;
        end
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
            if (n > 1 && n < 4 && disturb) check(!done, "R9 no early done", done, 0);
        end
        req = 0;
        ops_done++;
        if (w) begin
            check(n == wp_exp() + rec_exp(), "R7 write done cycle", n, wp_exp() + rec_exp());
            ref_mem[a] = d;
        end else begin
            check(n == rd_exp(), "R3 read done cycle", n, rd_exp());
            check(rdata == ref_get(a), "R3 read data", rdata, ref_get(a));
        end
        @(negedge clk);
        check(!done, "R3 done one clock", done, 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [18:0] pool [4];
        void'($urandom(32'h1234ABCD));
        repeat (3) @(negedge clk);
        check(cs_n && oe_n && we_n && !dq_oe && !done, "R1 pins in reset",
              {cs_n, oe_n, we_n, dq_oe, done}, 5'b11100);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(cs_n && oe_n && we_n && !dq_oe && !done, "R1 pins idle after reset",
              {cs_n, oe_n, we_n, dq_oe, done}, 5'b11100);
        // directed corner cases
        do_op(1, 19'h00000, 8'hA5, 0);
        do_op(1, 19'h7FFFF, 8'h3C, 0);
        do_op(0, 19'h00000, 8'h00, 0);
        do_op(0, 19'h7FFFF, 8'h00, 0);
        do_op(0, 19'h12345, 8'h00, 0);
        do_op(1, 19'h12345, 8'h77, 0);           // read followed by write: R4
        repeat (2) @(negedge clk);
        check(cs_n && oe_n && we_n && !dq_oe, "R1 idle between ops",
              {cs_n, oe_n, we_n, dq_oe}, 4'b1110);
        do_op(1, 19'h00F0F, 8'hC3, 1);           // disturbed write: R8 R9
        do_op(0, 19'h00F0F, 8'h00, 0);
        do_op(0, ~19'h00F0F, 8'h00, 0);           // untouched location: R9
        do_op(0, 19'h12345, 8'h00, 1);           // disturbed read: R8 R9
        // random traffic
        pool[0] = 19'h0; pool[1] = 19'h7FFFF;
        pool[2] = 19'($urandom); pool[3] = 19'($urandom);
        for (int i = 0; i < 60; i++) begin
            logic [18:0] a;
            a = ($urandom % 2) ? pool[$urandom % 4] : 19'($urandom);
            do_op(1'($urandom), a, 8'($urandom), ($urandom % 8) == 0);
        end
        repeat (10) @(negedge clk);
        check(done_seen == ops_done, "R9 done pulse count", done_seen, ops_done);
        check(!clash, "R10 no bus contention", clash, 0);
        finish_run();
    end
endmodule